// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between a memory controller's request logic and the command pins of an SDR SDRAM. It takes two level requests, one for self refresh and one for power-down. It follows which banks hold an open row from the activate and precharge strobes that the controller reports. It also owns the periodic refresh timer. From these inputs it drives the clock-enable line, the four command strobes and the A10 line, and it raises a busy flag whenever it controls the command bus. When busy is low the block drives NOP, and the controller may merge its own commands onto the bus.

The state machine has ten named states. From `ST_IDLE`, when no access is in flight, a pending refresh wins first, then self refresh, then power-down. If any row is open, a refresh or self-refresh request first passes through `ST_PRE`, which issues PRECHARGE with A10 high, and then `ST_TRP`, which waits out the precharge time. A refresh then runs `ST_REF` and `ST_RFWAIT` and returns to `ST_IDLE`. Self refresh runs `ST_SRENT`, where AUTO REFRESH is issued with CKE low, and then holds in `ST_SR`. It leaves `ST_SR` only once the request has dropped and the clock is reported stable. `ST_XSR` then keeps CKE high with NOPs for the exit time and returns to `ST_IDLE`. Power-down moves `ST_IDLE` to `ST_PD`. A dropped request or a pending refresh moves it to `ST_PDX`, one NOP cycle with CKE high, and then back to `ST_IDLE`.

The refresh timer wraps every `T_REFI` cycles and sets a pending flag. An AUTO REFRESH clears that flag. The timer is held at zero across self refresh, so its time base restarts on wake-up.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset: CKE high, command NOP (CS low; RAS, CAS and WE high), busy low, `pd_mode` = 0 and `in_sr` low.
- R2: With `pd_req` high while idle and no access is in flight, the next cycle shows CKE low with NOP and busy high. `access_busy`, `act_vld` or `pre_vld` high holds the block idle with CKE high.
- R3: `pd_mode` reads 1 during precharge power-down (no bank open at entry), 2 during active power-down (at least one bank open), and 0 at all other times.
- R4: When `pd_req` drops during power-down, the next cycle shows CKE high, NOP and busy high. The cycle after that shows busy low.
- R5: If a row is open when self refresh or refresh is due, the block first issues PRECHARGE (CS, RAS and WE low; CAS high) with A10 high. The next command follows exactly `T_RP` cycles later, with NOPs in between.
- R6: Self refresh starts with AUTO REFRESH (CS, RAS and CAS low; WE high) in the same cycle that CKE first goes low. `in_sr` is high from that cycle until CKE rises.
- R7: CKE stays low in self refresh while `clk_stable` is low, even after `sr_req` has dropped.
- R8: Once CKE rises out of self refresh, the block holds NOP with busy high for max(`T_XSR`, 2) cycles, then drops busy.
- R9: The refresh timer restarts from zero at self-refresh exit. The first AUTO REFRESH comes `T_REFI`+1 cycles after the first idle cycle. While the block stays idle, later AUTO REFRESH commands follow every `T_REFI` cycles.
- R10: AUTO REFRESH is issued only when no bank is open. Two AUTO REFRESH commands are always at least `T_RFC` cycles apart.
- R11: A refresh falling due during power-down forces an exit (CKE high with NOP) and an AUTO REFRESH, even while `pd_req` stays high. Power-down is re-entered afterwards.
- R12: If both sleep requests are high, self refresh is chosen. CKE only falls together with NOP or AUTO REFRESH, and busy is high whenever CKE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Level request to enter or stay in self refresh |
| pd_req | input | 1 | Level request to enter or stay in power-down |
| clk_stable | input | 1 | High when the memory clock is within its limits |
| access_busy | input | 1 | A read or write burst is still in flight |
| act_vld | input | 1 | The controller issues ACTIVATE this cycle |
| act_bank | input | BW | Bank of that ACTIVATE |
| pre_vld | input | 1 | The controller issues a single-bank PRECHARGE this cycle |
| pre_bank | input | BW | Bank of that PRECHARGE |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10; high selects all banks on PRECHARGE |
| busy | output | 1 | The block owns the bus; the controller must stay off it |
| pd_mode | output | 2 | 0 none, 1 precharge power-down, 2 active power-down |
| in_sr | output | 1 | High while the device is in self refresh |

## Verification
Each kind of wrong internal state shows up at the pins within a small, known number of cycles.

- **Open-row record:** a wrong record shows up as AUTO REFRESH while a bank is still open, or as PRECHARGE being skipped before self refresh. It also shows as a wrong `pd_mode`, visible on the first power-down cycle.
- **Delay counter:** a wrong count shifts the command after PRECHARGE away from `T_RP`. It also changes the length of the busy NOP run after CKE rises. Both errors appear within one window of the counter.
- **Refresh timer:** a timer that does not restart, or wraps at the wrong value, moves the first AUTO REFRESH after wake-up off `T_REFI`+1. This is seen within one refresh period.
- **State machine:** a mistaken transition shows as CKE falling with a command other than NOP or AUTO REFRESH, or rising before `clk_stable` is high. Both appear in the cycle of the edge.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_TRP,
        ST_REF,
        ST_RFWAIT,
        ST_SRENT,
        ST_SR,
        ST_XSR,
        ST_PD,
        ST_PDX
    } lp_state_e;

    typedef enum logic {
        TGT_REF,
        TGT_SR
    } lp_tgt_e;

    typedef enum logic [1:0] {
        PDM_NONE   = 2'd0,
        PDM_PRECHG = 2'd1,
        PDM_ACTIVE = 2'd2
    } pd_mode_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sd_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdram_lp_banks.sv
module sdram_lp_banks #(
    parameter int N_BANK = 4,
    parameter int BW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_vld,
    input  logic [BW-1:0] act_bank,
    input  logic          pre_vld,
    input  logic [BW-1:0] pre_bank,
    input  logic          clr_all,
    output logic          any_open
);

    logic [N_BANK-1:0] open_q;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        logic open_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_r <= 1'b0;
            end else if (clr_all || (pre_vld && pre_bank == BW'(b))) begin
                open_r <= 1'b0;
            end else if (act_vld && act_bank == BW'(b)) begin
                open_r <= 1'b1;
            end
        end
        assign open_q[b] = open_r;
    end

    assign any_open = |open_q;

endmodule

// File: rtl/sdram_lp_dly.sv
module sdram_lp_dly #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_lp_reftmr.sv
module sdram_lp_reftmr #(
    parameter int T_REFI = 780,
    parameter int W      = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic served,
    output logic pending
);

    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap = (cnt_q == W'(T_REFI - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else if (restart) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap) begin
                pending <= 1'b1;
            end else if (served) begin
                pending <= 1'b0;
            end
        end
    end

    // A wrap can only set the flag, never clear it.
    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !restart) |=> pending); // R9

endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
    import sdram_lp_pkg::*;
#(
    parameter int N_BANK = 4,
    parameter int BW     = (N_BANK > 1) ? $clog2(N_BANK) : 1,
    parameter int T_RP   = 3,
    parameter int T_RFC  = 8,
    parameter int T_XSR  = 12,
    parameter int T_REFI = 780
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sr_req,
    input  logic          pd_req,
    input  logic          clk_stable,
    input  logic          access_busy,
    input  logic          act_vld,
    input  logic [BW-1:0] act_bank,
    input  logic          pre_vld,
    input  logic [BW-1:0] pre_bank,
    output logic          cke,
    output logic          cs_n,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          a10,
    output logic          busy,
    output logic [1:0]    pd_mode,
    output logic          in_sr
);

    localparam int T_RP_E  = (T_RP  < 2) ? 2 : T_RP;
    localparam int T_RFC_E = (T_RFC < 2) ? 2 : T_RFC;
    localparam int XSR_E   = (T_XSR < 2) ? 2 : T_XSR;
    localparam int D_MAX   = (T_RP_E > T_RFC_E)
                           ? ((T_RP_E > XSR_E) ? T_RP_E : XSR_E)
                           : ((T_RFC_E > XSR_E) ? T_RFC_E : XSR_E);
    localparam int W_D     = $clog2(D_MAX + 1);
    localparam int W_REF   = (T_REFI > 2) ? $clog2(T_REFI) : 1;

    lp_state_e      state_q, state_d;
    lp_tgt_e        tgt_q, tgt_d;
    sd_cmd_t        cmd;
    logic           any_open;
    logic           dly_zero;
    logic           dly_load;
    logic [W_D-1:0] dly_val;
    logic           ref_pend;
    logic           quiet;

    sdram_lp_banks #(.N_BANK(N_BANK), .BW(BW)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_vld  (act_vld),
        .act_bank (act_bank),
        .pre_vld  (pre_vld),
        .pre_bank (pre_bank),
        .clr_all  (state_q == ST_PRE),
        .any_open (any_open)
    );

    sdram_lp_dly #(.W(W_D)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .zero     (dly_zero)
    );

    sdram_lp_reftmr #(.T_REFI(T_REFI), .W(W_REF)) u_reftmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == ST_SRENT || state_q == ST_SR || state_q == ST_XSR),
        .served  (state_q == ST_REF),
        .pending (ref_pend)
    );

    assign quiet = !access_busy && !act_vld && !pre_vld;

    // Next state and delay loads
    always_comb begin
        state_d  = state_q;
        tgt_d    = tgt_q;
        dly_load = 1'b0;
        dly_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (quiet) begin
                    if (ref_pend) begin
                        tgt_d   = TGT_REF;
                        state_d = any_open ? ST_PRE : ST_REF;
                    end else if (sr_req) begin
                        tgt_d   = TGT_SR;
                        state_d = any_open ? ST_PRE : ST_SRENT;
                    end else if (pd_req) begin
                        state_d = ST_PD;
                    end
                end
            end
            ST_PRE: begin
                dly_load = 1'b1;
                dly_val  = W_D'(T_RP_E - 2);
                state_d  = ST_TRP;
            end
            ST_TRP: begin
                if (dly_zero) begin
                    if (tgt_q == TGT_REF) begin
                        state_d = ST_REF;
                    end else begin
                        state_d = sr_req ? ST_SRENT : ST_IDLE;
                    end
                end
            end
            ST_REF: begin
                dly_load = 1'b1;
                dly_val  = W_D'(T_RFC_E - 2);
                state_d  = ST_RFWAIT;
            end
            ST_RFWAIT: begin
                if (dly_zero) state_d = ST_IDLE;
            end
            ST_SRENT: begin
                state_d = ST_SR;
            end
            ST_SR: begin
                if (!sr_req && clk_stable) begin
                    dly_load = 1'b1;
                    dly_val  = W_D'(XSR_E - 1);
                    state_d  = ST_XSR;
                end
            end
            ST_XSR: begin
                if (dly_zero) state_d = ST_IDLE;
            end
            ST_PD: begin
                if (!pd_req || ref_pend) state_d = ST_PDX;
            end
            ST_PDX: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= TGT_REF;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        cke     = 1'b1;
        cmd     = CMD_NOP;
        a10     = 1'b0;
        busy    = 1'b1;
        pd_mode = PDM_NONE;
        in_sr   = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_PRE: begin
                cmd = CMD_PRE;
                a10 = 1'b1;
            end
            ST_TRP:    ;
            ST_REF:    cmd = CMD_AREF;
            ST_RFWAIT: ;
            ST_SRENT: begin
                cke   = 1'b0;
                cmd   = CMD_AREF;
                in_sr = 1'b1;
            end
            ST_SR: begin
                cke   = 1'b0;
                in_sr = 1'b1;
            end
            ST_XSR:    ;
            ST_PD: begin
                cke     = 1'b0;
                pd_mode = any_open ? PDM_ACTIVE : PDM_PRECHG;
            end
            ST_PDX:    ;
            default:   busy = 1'b0;
        endcase
    end

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;

    // Spacing monitor for refresh commands
    logic [W_D-1:0] aref_gap;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aref_gap <= W_D'(T_RFC_E);
        end else if (cmd == CMD_AREF) begin
            aref_gap <= W_D'(1);
        end else if (aref_gap < W_D'(T_RFC_E)) begin
            aref_gap <= aref_gap + 1'b1;
        end
    end

    AST_CKE_FALL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (cmd == CMD_NOP || cmd == CMD_AREF)); // R12
    AST_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> busy); // R12
    AST_SR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sr) |-> (!cke && cmd == CMD_AREF)); // R6
    AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> a10); // R5
    AST_AREF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AREF) |-> !any_open); // R10
    AST_AREF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AREF) |-> (aref_gap >= W_D'(T_RFC_E))); // R10
    AST_EXIT_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cke) && $past(in_sr)) |-> $past(clk_stable)); // R7
    AST_XSR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cke) && $past(in_sr)) |=> (cmd == CMD_NOP && busy)); // R8
    AST_PDX_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd == CMD_NOP && busy)); // R4

endmodule

// File: tb/sdram_lp_seq_bench.sv
module sdram_lp_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_BANK = 4;
    localparam int BW     = 2;
    localparam int T_RP   = 3;
    localparam int T_RFC  = 4;
    localparam int T_XSR  = 1;
    localparam int T_REFI = 64;
    localparam int XSR_E  = (T_XSR < 2) ? 2 : T_XSR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_req = 1'b0, pd_req = 1'b0, clk_stable = 1'b1, access_busy = 1'b0;
    logic act_vld = 1'b0, pre_vld = 1'b0;
    logic [BW-1:0] act_bank = '0, pre_bank = '0;
    logic cke, cs_n, ras_n, cas_n, we_n, a10, busy, in_sr;
    logic [1:0] pd_mode;

    int n_chk = 0;
    int n_fail = 0;
    logic [N_BANK-1:0] mask = '0;
    logic prev_cke = 1'b1, prev_in_sr = 1'b0;
    bit   xsr_trk = 1'b0;
    int   xsr_n = 0;
    int   gap = 1000;
    bit   mon_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_lp_seq #(.N_BANK(N_BANK), .BW(BW), .T_RP(T_RP), .T_RFC(T_RFC),
                   .T_XSR(T_XSR), .T_REFI(T_REFI)) u_sdram_lp_seq (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .pd_req(pd_req),
        .clk_stable(clk_stable), .access_busy(access_busy),
        .act_vld(act_vld), .act_bank(act_bank), .pre_vld(pre_vld), .pre_bank(pre_bank),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .a10(a10), .busy(busy), .pd_mode(pd_mode), .in_sr(in_sr));

    function automatic bit is_nop();
        return !cs_n && ras_n && cas_n && we_n;
    endfunction
    function automatic bit is_pre();
        return !cs_n && !ras_n && cas_n && !we_n;
    endfunction
    function automatic bit is_aref();
        return !cs_n && !ras_n && !cas_n && we_n;
    endfunction
    function automatic int exp_mode(input logic [N_BANK-1:0] m);
        return (m != '0) ? 2 : 1;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic monitor();
        if (!prev_cke && cke && prev_in_sr) begin
            chk(clk_stable == 1'b1, "R7 exit with clock stable", clk_stable, 1);
            xsr_trk = 1'b1;
            xsr_n = 0;
        end
        if (xsr_trk) begin
            if (busy) begin
                chk(is_nop() && cke, "R8 NOP during exit", {cs_n, ras_n, cas_n, we_n}, 7);
                xsr_n++;
            end else begin
                chk(xsr_n == XSR_E, "R8 exit length", xsr_n, XSR_E);
                xsr_trk = 1'b0;
            end
        end
        if (prev_cke && !cke)
            chk(is_nop() || is_aref(), "R12 command at CKE fall", {cs_n, ras_n, cas_n, we_n}, 7);
        if (!cke)
            chk(busy == 1'b1, "R12 busy while CKE low", busy, 1);
        if (!cke && !in_sr)
            chk(pd_mode == 2'(exp_mode(mask)), "R3 power-down mode", pd_mode, exp_mode(mask));
        if (cke && !in_sr && pd_mode != 2'd0)
            chk(1'b0, "R3 mode outside power-down", pd_mode, 0);
        if (is_aref()) begin
            chk(mask == '0, "R10 all banks closed at refresh", mask, 0);
            chk(gap >= T_RFC, "R10 refresh spacing", gap, T_RFC);
            gap = 0;
        end
        if (is_pre() && a10) mask = '0;
        if (gap < 1000) gap++;
        prev_cke = cke;
        prev_in_sr = in_sr;
    endtask

    task automatic step();
        @(negedge clk);
        if (mon_en) monitor();
    endtask

    task automatic do_act(input int b);
        act_vld = 1'b1;
        act_bank = BW'(b);
        mask[b] = 1'b1;
        step();
        act_vld = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && busy; i++) step();
    endtask

    task automatic sync_ref();
        int k;
        k = 0;
        while (!is_aref() && k < 300) begin
            step();
            k++;
        end
        step();
        wait_idle();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        int unsigned r;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        step();
        // R1 reset state
        chk(cke && is_nop() && !busy && pd_mode == 2'd0 && !in_sr, "R1 reset outputs",
            {cke, cs_n, ras_n, cas_n, we_n, busy, in_sr, pd_mode}, 9'b1_0111_0_0_00);

        // R2/R3 precharge power-down entry, R4 exit
        pd_req = 1'b1;
        step();
        chk(!cke && busy && is_nop(), "R2 power-down entry", {cke, busy}, 2'b01);
        chk(pd_mode == 2'd1, "R3 precharge power-down", pd_mode, 1);
        repeat (3) step();
        chk(!cke, "R2 power-down held", cke, 0);
        pd_req = 1'b0;
        step();
        chk(cke && is_nop() && busy, "R4 exit NOP cycle", {cke, busy}, 2'b11);
        step();
        chk(!busy && cke, "R4 busy released", busy, 0);

        // R2 blocked by an access in flight
        access_busy = 1'b1;
        pd_req = 1'b1;
        repeat (3) step();
        chk(cke && !busy, "R2 held off by access", {cke, busy}, 2'b10);
        access_busy = 1'b0;
        step();
        chk(!cke, "R2 entry after access ends", cke, 0);
        pd_req = 1'b0;
        step();
        step();

        // R3 active power-down
        do_act(2);
        pd_req = 1'b1;
        step();
        chk(!cke && pd_mode == 2'd2, "R3 active power-down", pd_mode, 2);
        pd_req = 1'b0;
        step();
        step();

        // R5/R6/R12 self refresh with an open row and both requests high
        sync_ref();
        do_act(1);
        sr_req = 1'b1;
        pd_req = 1'b1;
        step();
        chk(is_pre() && a10 && cke, "R5 precharge-all first", {cs_n, ras_n, cas_n, we_n, a10}, 5'b00101);
        n = 0;
        while (!is_aref() && n < 20) begin
            step();
            n++;
        end
        chk(n == T_RP, "R5 precharge to next command", n, T_RP);
        chk(!cke && in_sr, "R12 self refresh preferred, R6 entry", {cke, in_sr}, 2'b01);
        pd_req = 1'b0;
        repeat (3) step();
        chk(!cke && in_sr && is_nop(), "R6 held in self refresh", {cke, in_sr}, 2'b01);
        sr_req = 1'b0;
        clk_stable = 1'b0;
        repeat (4) step();
        chk(!cke, "R7 wait for stable clock", cke, 0);
        clk_stable = 1'b1;
        step();
        chk(cke && is_nop() && busy, "R8 first exit cycle", {cke, busy}, 2'b11);
        n = 1;
        step();
        while (busy && n < 50) begin
            n++;
            step();
        end
        chk(n == XSR_E, "R8 exit NOP count", n, XSR_E);

        // R9 timer restart and period
        n = 0;
        while (!is_aref() && n < 500) begin
            step();
            n++;
        end
        chk(n == T_REFI + 1, "R9 first refresh after wake-up", n, T_REFI + 1);
        n = 0;
        step();
        n++;
        while (!is_aref() && n < 500) begin
            step();
            n++;
        end
        chk(n == T_REFI, "R9 refresh period", n, T_REFI);

        // R11 refresh forces power-down exit
        wait_idle();
        pd_req = 1'b1;
        step();
        chk(!cke, "R11 power-down entered", cke, 0);
        n = 0;
        while (!cke && n < T_REFI + 5) begin
            step();
            n++;
        end
        chk(cke && pd_req && is_nop(), "R11 forced exit", {cke, pd_req}, 2'b11);
        n = 0;
        while (!is_aref() && n < 5) begin
            step();
            n++;
        end
        chk(is_aref(), "R11 refresh after forced exit", is_aref(), 1);
        n = 0;
        while (cke && n < 10) begin
            step();
            n++;
        end
        chk(!cke, "R11 power-down re-entered", cke, 0);
        pd_req = 1'b0;
        step();
        step();

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int b;
            step();
            act_vld = 1'b0;
            pre_vld = 1'b0;
            r = $urandom;
            if (r % 100 < 3) pd_req = !pd_req;
            if (((r >> 8) % 100) < 2) sr_req = !sr_req;
            clk_stable = (((r >> 16) % 100) >= 10);
            access_busy = (((r >> 24) % 100) < 15);
            if (!busy && ((r >> 4) % 8) == 0) begin
                b = int'($urandom % N_BANK);
                if ($urandom % 2 == 0) begin
                    act_vld = 1'b1;
                    act_bank = BW'(b);
                    mask[b] = 1'b1;
                end else begin
                    pre_vld = 1'b1;
                    pre_bank = BW'(b);
                    mask[b] = 1'b0;
                end
            end
        end
        step();
        summary();
        $finish;
    end

endmodule